// File: doc/BRIEF.md
# Stack Pointer Doubleword Modifier

This block adjusts a packed push-down stack descriptor by a signed amount in a single operation. The 64-bit descriptor holds a 17-bit top-of-stack address, a 15-bit count of free slots (space count) and a 15-bit count of occupied slots (word count). A signed 16-bit modifier, taken from the low half of a 32-bit register operand, is added to the address, subtracted from the space count and added to the word count. All three fields move together or not at all.

If either new count would fall below zero or rise above 32767, the update is abandoned and the descriptor comes back unchanged. Two inhibit inputs, one per count, then decide the outcome. An uninhibited violation raises a trap request, meant to send control to the stack-limit vector at 0x42. When every violated count is inhibited, only a condition code is written. Fetching and storing the descriptor is left to the surrounding logic. The block registers its result one cycle after a valid strobe, with write enables for the descriptor and for the condition code.

Top module: `stack_ptr_mod`

## Requirements
- R1: While `rstN` is low, `resValid`, `dwWe`, `ccWe`, `trapReq`, `dwOut` and `ccOut` are all zero.
- R2: `resValid` is high in the cycle after each cycle with `inValid` high and low otherwise. `dwWe`, `ccWe` and `trapReq` are high only while `resValid` is high.
- R3: On success, `dwOut[48:32]` equals `dwIn[48:32]` plus the sign-extended modifier `regIn[15:0]`, modulo 2^17.
- R4: On success, `dwOut[30:16]` (space count) equals the old space count minus the modifier, and `dwOut[14:0]` (word count) equals the old word count plus the modifier. `dwWe` is 1.
- R5: `dwOut` bits 63:49, 31 and 15 always equal the same bits of `dwIn`.
- R6: If the new space count or the new word count lies outside 0..32767, `dwWe` is 0 and `dwOut` equals `dwIn`.
- R7: `ccOut` encoding: bit 3 is space-count violation, bit 2 is word-count violation, bit 1 is new space count zero, bit 0 is new word count zero. On success bits 3:2 are 0. On abort bits 1:0 are 0.
- R8: `trapReq` is 1 when a violated count has its inhibit input low (`spInhibit` for space, `wdInhibit` for word). `ccWe` is then 0.
- R9: When at least one count is violated and every violated count is inhibited, `trapReq` is 0, `ccWe` is 1 and `ccOut` shows the violations.
- R10: Wraparound of the address field never aborts the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| dwIn | input | 64 | Current stack descriptor |
| regIn | input | 32 | Register operand; modifier in bits 15:0 |
| spInhibit | input | 1 | Suppresses trap for space-count violation |
| wdInhibit | input | 1 | Suppresses trap for word-count violation |
| resValid | output | 1 | Result valid, one cycle after strobe |
| dwOut | output | 64 | Updated (or unchanged) descriptor |
| dwWe | output | 1 | Descriptor write enable |
| ccOut | output | 4 | Condition code |
| ccWe | output | 1 | Condition code write enable |
| trapReq | output | 1 | Stack-limit trap request |

## Verification
The hardest cases are those where both counts are violated together but only one is inhibited, and those where a count lands exactly on 0 or 32767. Ordinary random descriptors rarely produce them. The stimulus builds descriptors whose counts sit next to these edges and picks modifiers that push one count or both just across them. It walks through all four inhibit combinations for each case. Address-wrap cases use an address at each end of the 17-bit range, combined with legal counts, so that a wrap shows up without any abort.

// File: rtl/stack_ptr_mod_pkg.sv
package stack_ptr_mod_pkg;
  typedef struct packed {
    logic load;
    logic commitDw;
    logic commitCc;
    logic trap;
  } dpStrobe_t;
endpackage

// File: rtl/stack_ptr_mod_dp.sv
module stack_ptr_mod_dp
  import stack_ptr_mod_pkg::*;
#(
  parameter int DW_W   = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 15,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DW_W-1:0]   dwIn,
  input  logic [REG_W-1:0]  regIn,
  input  dpStrobe_t         strobe,
  output logic              spBad,
  output logic              wdBad,
  output logic [DW_W-1:0]   dwOut,
  output logic              dwWe,
  output logic [3:0]        ccOut,
  output logic              ccWe,
  output logic              trapReq
);
  localparam int WC_LSB = 0;
  localparam int SC_LSB = CNT_W + 1;
  localparam int AD_LSB = 2 * CNT_W + 2;
  localparam int SUM_W  = ((CNT_W > MOD_W) ? CNT_W : MOD_W) + 2;

  logic [MOD_W-1:0]  modVal;
  logic [ADDR_W-1:0] addrOld, addrNew;
  logic [CNT_W-1:0]  spOld, wdOld;
  logic [SUM_W-1:0]  modWide, spSum, wdSum;
  logic              spZero, wdZero, abortNow;
  logic [DW_W-1:0]   dwNew;
  logic [3:0]        ccNext;

  assign modVal  = regIn[MOD_W-1:0];
  assign addrOld = dwIn[AD_LSB +: ADDR_W];
  assign spOld   = dwIn[SC_LSB +: CNT_W];
  assign wdOld   = dwIn[WC_LSB +: CNT_W];
  assign modWide = {{(SUM_W-MOD_W){modVal[MOD_W-1]}}, modVal};

  // address wraps modulo 2^ADDR_W, never a fault
  assign addrNew = addrOld + modWide[ADDR_W-1:0];
  assign spSum   = {{(SUM_W-CNT_W){1'b0}}, spOld} - modWide;
  assign wdSum   = {{(SUM_W-CNT_W){1'b0}}, wdOld} + modWide;

  // any set bit above the count width means negative or too large
  assign spBad    = |spSum[SUM_W-1:CNT_W];
  assign wdBad    = |wdSum[SUM_W-1:CNT_W];
  assign spZero   = (spSum[CNT_W-1:0] == '0);
  assign wdZero   = (wdSum[CNT_W-1:0] == '0);
  assign abortNow = spBad | wdBad;

  always_comb begin
    dwNew = dwIn;
    dwNew[AD_LSB +: ADDR_W] = addrNew;
    dwNew[SC_LSB +: CNT_W]  = spSum[CNT_W-1:0];
    dwNew[WC_LSB +: CNT_W]  = wdSum[CNT_W-1:0];
    if (abortNow) ccNext = {spBad, wdBad, 2'b00};
    else          ccNext = {2'b00, spZero, wdZero};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwOut   <= '0;
      ccOut   <= '0;
      dwWe    <= 1'b0;
      ccWe    <= 1'b0;
      trapReq <= 1'b0;
    end else begin
      dwWe    <= strobe.commitDw;
      ccWe    <= strobe.commitCc;
      trapReq <= strobe.trap;
      if (strobe.load) begin
        dwOut <= strobe.commitDw ? dwNew : dwIn;
        ccOut <= ccNext;
      end
    end
  end

  p_cc_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    dwWe |-> (ccOut[3:2] == 2'b00));
  p_abort_flags_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ccWe && !dwWe) |-> (ccOut[3:2] != 2'b00 && ccOut[1:0] == 2'b00));
  p_trap_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (!dwWe && !ccWe));
  p_trap_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (ccOut[3:2] != 2'b00));
endmodule

// File: rtl/stack_ptr_mod_ctrl.sv
module stack_ptr_mod_ctrl
  import stack_ptr_mod_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      spBad,
  input  logic      wdBad,
  input  logic      spInhibit,
  input  logic      wdInhibit,
  output dpStrobe_t strobe,
  output logic      resValid
);
  logic abortNow, trapNow;

  assign abortNow = spBad | wdBad;
  assign trapNow  = (spBad & ~spInhibit) | (wdBad & ~wdInhibit);

  always_comb begin
    strobe.load     = inValid;
    strobe.commitDw = inValid & ~abortNow;
    strobe.commitCc = inValid & ~trapNow;
    strobe.trap     = inValid & trapNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
  p_one_action_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.commitDw, strobe.trap}) <= 1);
endmodule

// File: rtl/stack_ptr_mod.sv
module stack_ptr_mod
  import stack_ptr_mod_pkg::*;
#(
  parameter int DW_W   = 64,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 15,
  parameter int MOD_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DW_W-1:0]   dwIn,
  input  logic [REG_W-1:0]  regIn,
  input  logic              spInhibit,
  input  logic              wdInhibit,
  output logic              resValid,
  output logic [DW_W-1:0]   dwOut,
  output logic              dwWe,
  output logic [3:0]        ccOut,
  output logic              ccWe,
  output logic              trapReq
);
  dpStrobe_t strobe;
  logic      spBad, wdBad;

  stack_ptr_mod_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .spBad(spBad), .wdBad(wdBad),
    .spInhibit(spInhibit), .wdInhibit(wdInhibit),
    .strobe(strobe), .resValid(resValid)
  );

  stack_ptr_mod_dp #(
    .DW_W(DW_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MOD_W(MOD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dwIn(dwIn), .regIn(regIn), .strobe(strobe),
    .spBad(spBad), .wdBad(wdBad), .dwOut(dwOut), .dwWe(dwWe),
    .ccOut(ccOut), .ccWe(ccWe), .trapReq(trapReq)
  );

  p_pulse_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dwWe || ccWe || trapReq) |-> resValid);
  p_result_act_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (dwWe || trapReq || ccWe));
endmodule

// File: tb/sim_stack_ptr_mod.sv
`timescale 1ns/1ps
module sim_stack_ptr_mod;
  typedef struct {
    logic [63:0] dw;
    logic        dwWe;
    logic [3:0]  cc;
    logic        ccWe;
    logic        trap;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] dwIn = '0;
  logic [31:0] regIn = '0;
  logic        spInhibit = 1'b0, wdInhibit = 1'b0;
  logic        resValid, dwWe, ccWe, trapReq;
  logic [63:0] dwOut;
  logic [3:0]  ccOut;

  int nChecks = 0;
  int nFails  = 0;
  expItem_t sb[$];

  always #2.5 clk = ~clk;

  stack_ptr_mod u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dwIn(dwIn), .regIn(regIn),
    .spInhibit(spInhibit), .wdInhibit(wdInhibit), .resValid(resValid),
    .dwOut(dwOut), .dwWe(dwWe), .ccOut(ccOut), .ccWe(ccWe), .trapReq(trapReq)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkDw(input logic [14:0] hi, input logic [16:0] addr,
      input logic ts, input logic [14:0] sp, input logic tw, input logic [14:0] wc);
    return {hi, addr, ts, sp, tw, wc};
  endfunction

  // independent model of the requirements
  task automatic drive(input logic [63:0] dw, input logic [15:0] m16,
                       input logic si, input logic wi, input string tag);
    expItem_t e;
    int m, ns, nw;
    bit sBad, wBad, abrt, trp;
    logic [16:0] na;
    m  = int'($signed(m16));
    ns = int'(dw[30:16]) - m;
    nw = int'(dw[14:0]) + m;
    sBad = (ns < 0) || (ns > 32767);
    wBad = (nw < 0) || (nw > 32767);
    abrt = sBad || wBad;
    trp  = (sBad && !si) || (wBad && !wi);
    na   = dw[48:32] + 17'(m);
    e.dw = abrt ? dw : {dw[63:49], na, dw[31], ns[14:0], dw[15], nw[14:0]};
    e.dwWe = !abrt;
    e.ccWe = !trp;
    e.trap = trp;
    e.cc = abrt ? {sBad, wBad, 2'b00} : {2'b00, ns == 0, nw == 0};
    e.tag = tag;
    @(negedge clk);
    dwIn = dw;
    regIn = {$urandom_range(0, 65535) & 32'hFFFF, 16'h0} | {16'h0, m16};
    spInhibit = si;
    wdInhibit = wi;
    inValid = 1'b1;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor: pops an expected item per result
  always @(negedge clk) begin
    if (rstN) begin
      if (resValid) begin
        if (sb.size() == 0) begin
          chk(0, "R2", "unexpected result", 64'(resValid), 64'd0);
        end else begin
          expItem_t e;
          e = sb.pop_front();
          chk(dwOut == e.dw, e.tag, "dwOut", dwOut, e.dw);
          chk(dwOut[63:49] == e.dw[63:49] && dwOut[31] == e.dw[31] && dwOut[15] == e.dw[15],
              "R5", "pass-through bits", dwOut, e.dw);
          chk(dwWe == e.dwWe, e.dwWe ? "R4" : "R6", "dwWe", 64'(dwWe), 64'(e.dwWe));
          chk(ccOut == e.cc, "R7", "ccOut", 64'(ccOut), 64'(e.cc));
          chk(ccWe == e.ccWe, e.trap ? "R8" : "R9", "ccWe", 64'(ccWe), 64'(e.ccWe));
          chk(trapReq == e.trap, e.trap ? "R8" : "R9", "trapReq", 64'(trapReq), 64'(e.trap));
        end
      end else begin
        chk(!(dwWe || ccWe || trapReq), "R2", "enables while idle",
            64'({dwWe, ccWe, trapReq}), 64'd0);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({resValid, dwWe, ccWe, trapReq} == 4'b0, "R1", "enables in reset",
        64'({resValid, dwWe, ccWe, trapReq}), 64'd0);
    chk(dwOut == 64'd0 && ccOut == 4'd0, "R1", "data in reset", dwOut, 64'd0);
    rstN = 1'b1;
    idle(2);

    // R3/R4 plain success, positive and negative modifiers
    drive(mkDw(15'h1234, 17'h00100, 1'b1, 15'd100, 1'b0, 15'd50), 16'd10, 1'b0, 1'b0, "R3");
    drive(mkDw(15'h7FFF, 17'h00100, 1'b0, 15'd100, 1'b1, 15'd50), -16'sd20, 1'b0, 1'b0, "R4");
    drive(mkDw(15'h0001, 17'h0ABCD, 1'b1, 15'd7, 1'b1, 15'd9), 16'd0, 1'b0, 1'b0, "R4");
    idle(2);
    // R10: address wrap up and down, counts legal
    drive(mkDw(15'h0, 17'h1FFFF, 1'b0, 15'd10, 1'b0, 15'd10), 16'd1, 1'b0, 1'b0, "R10");
    drive(mkDw(15'h0, 17'h00000, 1'b0, 15'd10, 1'b0, 15'd10), -16'sd3, 1'b0, 1'b0, "R10");
    idle(1);
    // R7: zero flags exactly at the edges
    drive(mkDw(15'h0, 17'h00040, 1'b0, 15'd5, 1'b0, 15'd32762), 16'd5, 1'b0, 1'b0, "R7");
    drive(mkDw(15'h0, 17'h00040, 1'b0, 15'd32764, 1'b0, 15'd3), -16'sd3, 1'b0, 1'b0, "R7");
    idle(1);
    // R6/R8/R9: space underflow, word overflow, word underflow, both bad
    for (int inh = 0; inh < 4; inh++) begin
      logic si, wi;
      si = inh[0];
      wi = inh[1];
      drive(mkDw(15'h2AAA, 17'h00200, si, 15'd5, wi, 15'd100), 16'd6, si, wi, "R6");
      drive(mkDw(15'h2AAA, 17'h00200, si, 15'd32000, wi, 15'd32767), 16'd1, si, wi, "R6");
      drive(mkDw(15'h2AAA, 17'h00200, si, 15'd10, wi, 15'd4), -16'sd5, si, wi, "R6");
      drive(mkDw(15'h1555, 17'h00200, si, 15'd5, wi, 15'd32767), 16'h7FFF, si, wi, "R6");
      drive(mkDw(15'h1555, 17'h1FFF0, si, 15'd32767, wi, 15'd0), -16'sd32768, si, wi, "R6");
      idle(1);
    end
    // random sweep near and away from the limits
    for (int i = 0; i < 200; i++) begin
      logic [14:0] sp, wc;
      logic [15:0] m;
      sp = 15'($urandom);
      wc = 15'($urandom);
      m  = (i % 2 == 0) ? 16'($urandom) : 16'($signed(16'($urandom_range(0, 64))) - 16'sd32);
      drive({$urandom, 32'h0} | {32'h0, $urandom} & 64'hFFFF_FFFF_FFFF_FFFF
            ^ {64'h0} | mkDw(15'($urandom), 17'($urandom), i[0], sp, i[1], wc),
            m, i[2], i[3], "R4");
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    chk(sb.size() == 0, "R2", "results outstanding", 64'(sb.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule